// File: doc/BRIEF.md
# Residue-Arithmetic FIR Filter

This block is a transposed-form FIR filter with run-time loadable coefficients. Its arithmetic is exact. Each accepted signed sample is split into six residues, one for each modulus in the fixed set {3, 5, 7, 11, 17, 64}. Each residue goes to its own narrow channel. That channel holds the coefficients and partial sums reduced to the same modulus and does a modular multiply-accumulate at every tap. The six channel results are then recombined by the Chinese remainder theorem into a signed binary result.

The product of the moduli, M = 1,256,640, is larger than 2^20. The recombined value v therefore stands for v when v < M/2 and for v - M otherwise. Elaboration-time checks refuse any parameter set whose worst-case sum could reach M/2, and any output width that cannot hold that range. Setting the `CONV_ONLY` parameter builds a variant that replaces the channels with a plain residue register, so that the two converters can be exercised in cascade with the same latency.

Top module: `rns_fir`

## Requirements
- R1: For every accepted sample, out_result equals the exact sum over k = 0..NTAPS-1 of c_k * x(n-k). Here x(n-k) is the k-th most recent accepted sample, counting the current one as k = 0, and c_k is the coefficient held at tap index k.
- R2: Samples, coefficients and results are signed two's complement. A negative operand is mapped into residues by adding M. A recombined value of M/2 or more is reported as that value minus M, so negative sums come out correctly.
- R3: out_valid is high exactly 3 clock cycles after each cycle in which in_valid is high, and is low in every other cycle.
- R4: The tap state advances only on cycles with in_valid high. Idle cycles between samples leave the later outputs unchanged.
- R5: A cycle with coef_we high and coef_idx below NTAPS loads coef_val into that tap. A write with coef_idx at or above NTAPS changes no coefficient.
- R6: An active-low reset clears every partial sum and every coefficient to zero and drives out_valid and out_result to 0.
- R7: Full-scale operands, with all coefficients and samples at -2^(W-1), give exact results with no wrap.
- R8: With CONV_ONLY set, out_result equals the sample accepted 3 cycles earlier, for every representable input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | IDX_W | Tap index to write |
| coef_val | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | Result strobe |
| out_result | output | OUT_W | Signed filter result |

## Verification
For each of several coefficient sets, the bench drives all 256 sample values in a scrambled order: a unit impulse tap, mixed signs, all taps at negative full scale, and a set with idle gaps between samples. A wrong negative mapping, or a wrong sign fold after recombination, shows up as results that are off by M or have the wrong sign. A missing modular reduction gives large wrong values at full scale. A tap that advances on idle cycles shifts the samples seen by the later outputs. Writes to tap indices beyond the filter length would corrupt a coefficient. The bench also clears the filter with reset after it has been running with nonzero partial sums, so stale sums or stale coefficients would leak into the first outputs. The conversion-only build is swept over every input to expose any converter constant that is wrong.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;

   localparam int NUM_CH = 6;
   localparam int RES_W  = 6;

   typedef logic [NUM_CH-1:0][RES_W-1:0] res_vec_t;

   function automatic int unsigned ch_modulus(input int idx);
      case (idx)
         0:       return 3;
         1:       return 5;
         2:       return 7;
         3:       return 11;
         4:       return 17;
         default: return 64;
      endcase
   endfunction

   function automatic longint unsigned range_total();
      longint unsigned p;
      p = 1;
      for (int i = 0; i < NUM_CH; i++) p = p * longint'(ch_modulus(i));
      return p;
   endfunction

   localparam longint unsigned M_TOTAL = range_total();
   localparam longint unsigned M_HALF  = M_TOTAL / 2;

   function automatic longint unsigned crt_weight(input int idx);
      longint unsigned m;
      longint unsigned part;
      longint unsigned inv;
      m    = longint'(ch_modulus(idx));
      part = M_TOTAL / m;
      inv  = 0;
      for (int j = 1; j < 64; j++)
         if (longint'(j) < m && ((part % m) * longint'(j)) % m == 1) inv = longint'(j);
      return (part * inv) % M_TOTAL;
   endfunction

   function automatic int unsigned to_residue(input longint signed v, input int unsigned m);
      longint signed u;
      u = (v < 0) ? v + longint'(M_TOTAL) : v;
      return int'(u % longint'(m));
   endfunction

endpackage

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv
   import rns_fir_pkg::*;
#(
   parameter int IN_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_data,
   output logic                   out_valid,
   output res_vec_t               out_res
);

   res_vec_t res_d;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         localparam int unsigned MOD = ch_modulus(ch);
         assign res_d[ch] = RES_W'(to_residue(longint'(in_data), MOD));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_res <= res_d;
      end
   end

   AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == '0) |=> (out_res == '0)); // R2

endmodule

// File: rtl/rns_channel.sv
module rns_channel
   import rns_fir_pkg::*;
#(
   parameter int MODULUS = 3,
   parameter int NTAPS   = 4,
   parameter int COEF_W  = 8,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid,
   input  logic [RES_W-1:0]         smp_res,
   input  logic                     coef_we,
   input  logic [IDX_W-1:0]         coef_idx,
   input  logic signed [COEF_W-1:0] coef_val,
   output logic                     out_valid,
   output logic [RES_W-1:0]         out_res
);

   logic [NTAPS-1:0][RES_W-1:0] coef_q;
   logic [NTAPS-1:1][RES_W-1:0] psum_q;
   logic [NTAPS-1:1][RES_W-1:0] psum_d;
   logic [RES_W-1:0]            coef_res;

   function automatic logic [RES_W-1:0] mod_mac(input logic [RES_W-1:0] acc,
                                                 input logic [RES_W-1:0] a,
                                                 input logic [RES_W-1:0] x);
      int unsigned t;
      t = int'(acc) + int'(a) * int'(x);
      return RES_W'(t % int'(MODULUS));
   endfunction

   assign coef_res = RES_W'(to_residue(longint'(coef_val), MODULUS));

   generate
      for (genvar k = 1; k < NTAPS; k++) begin : g_tap
         if (k == NTAPS - 1) begin : g_head
            assign psum_d[k] = mod_mac('0, coef_q[k], smp_res);
         end else begin : g_mid
            assign psum_d[k] = mod_mac(psum_q[k+1], coef_q[k], smp_res);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q <= '0;
      end else if (coef_we) begin
         for (int k = 0; k < NTAPS; k++)
            if (coef_idx == IDX_W'(k)) coef_q[k] <= coef_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psum_q    <= '0;
         out_res   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid) begin
            psum_q  <= psum_d;
            out_res <= mod_mac(psum_q[1], coef_q[0], smp_res);
         end
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(psum_q) && $stable(out_res))); // R4

   AST_COEF_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && int'(coef_idx) >= NTAPS) |=> $stable(coef_q)); // R5

endmodule

// File: rtl/rns_rev_conv.sv
module rns_rev_conv
   import rns_fir_pkg::*;
#(
   parameter int OUT_W = 21
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  res_vec_t                in_res,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_data
);

   logic [63:0]        term [NUM_CH];
   logic [63:0]        acc;
   logic [63:0]        folded;
   logic signed [63:0] value;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_term
         localparam longint unsigned WT = crt_weight(ch);
         assign term[ch] = 64'(in_res[ch]) * 64'(WT);
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int ch = 0; ch < NUM_CH; ch++) acc = acc + term[ch];
      folded = acc % 64'(M_TOTAL);
      if (folded >= 64'(M_HALF)) value = $signed(folded) - $signed(64'(M_TOTAL));
      else                       value = $signed(folded);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= OUT_W'(value);
      end
   end

   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(out_data) >= -longint'(M_HALF) &&
                     longint'(out_data) <  longint'(M_HALF))); // R2

endmodule

// File: rtl/rns_fir.sv
module rns_fir
   import rns_fir_pkg::*;
#(
   parameter int NTAPS     = 4,
   parameter int DATA_W    = 8,
   parameter int COEF_W    = 8,
   parameter int IDX_W     = 3,
   parameter int OUT_W     = 21,
   parameter bit CONV_ONLY = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic                     coef_we,
   input  logic [IDX_W-1:0]         coef_idx,
   input  logic signed [COEF_W-1:0] coef_val,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_result
);

   localparam longint unsigned PEAK =
      longint'(NTAPS) * (64'd1 << (DATA_W - 1)) * (64'd1 << (COEF_W - 1));
   localparam longint unsigned OUT_SPAN = 64'd1 << (OUT_W - 1);

   initial begin
      if (NTAPS < 2)                          $fatal(1, "NTAPS must be at least 2");
      if ((64'd1 << IDX_W) < longint'(NTAPS)) $fatal(1, "IDX_W too narrow for NTAPS");
      if (PEAK >= M_HALF)                     $fatal(1, "worst-case sum exceeds residue range");
      if (OUT_SPAN < M_HALF)                  $fatal(1, "OUT_W cannot hold the residue range");
   end

   logic     fwd_valid;
   res_vec_t fwd_res;
   logic     mid_valid;
   res_vec_t mid_res;

   rns_fwd_conv #(.IN_W(DATA_W)) u_fwd (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_sample),
      .out_valid(fwd_valid),
      .out_res  (fwd_res)
   );

   generate
      if (CONV_ONLY) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mid_valid <= 1'b0;
               mid_res   <= '0;
            end else begin
               mid_valid <= fwd_valid;
               if (fwd_valid) mid_res <= fwd_res;
            end
         end

         AST_CASCADE_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (longint'(out_result) == longint'($past(in_sample, 3)))); // R8
      end else begin : g_filter
         logic [NUM_CH-1:0] ch_valid;
         for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            rns_channel #(
               .MODULUS(int'(ch_modulus(ch))),
               .NTAPS  (NTAPS),
               .COEF_W (COEF_W),
               .IDX_W  (IDX_W)
            ) u_ch (
               .clk      (clk),
               .rst_n    (rst_n),
               .smp_valid(fwd_valid),
               .smp_res  (fwd_res[ch]),
               .coef_we  (coef_we),
               .coef_idx (coef_idx),
               .coef_val (coef_val),
               .out_valid(ch_valid[ch]),
               .out_res  (mid_res[ch])
            );
         end
         assign mid_valid = &ch_valid;
      end
   endgenerate

   rns_rev_conv #(.OUT_W(OUT_W)) u_rev (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (mid_valid),
      .in_res   (mid_res),
      .out_valid(out_valid),
      .out_data (out_result)
   );

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##2 out_valid); // R3

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3)); // R3

endmodule

// File: tb/tb_rns_fir.sv
`timescale 1ns/1ps
module tb_rns_fir;

   localparam int NT = 4;
   localparam int DW = 8;
   localparam int CW = 8;
   localparam int IW = 3;
   localparam int OW = 21;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_sample = '0;
   logic                 coef_we = 1'b0;
   logic [IW-1:0]        coef_idx = '0;
   logic signed [CW-1:0] coef_val = '0;
   logic                 f_valid, c_valid;
   logic signed [OW-1:0] f_result, c_result;

   rns_fir #(.NTAPS(NT), .DATA_W(DW), .COEF_W(CW), .IDX_W(IW), .OUT_W(OW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
      .out_valid(f_valid), .out_result(f_result));

   rns_fir #(.NTAPS(NT), .DATA_W(DW), .COEF_W(CW), .IDX_W(IW), .OUT_W(OW),
             .CONV_ONLY(1'b1)) dut_conv (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .coef_we(1'b0), .coef_idx('0), .coef_val('0),
      .out_valid(c_valid), .out_result(c_result));

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";
   int    coef [NT];
   int    hist [NT];
   int    q_val [1024];
   int    q_due [1024];
   int    q_wr = 0, q_rd = 0;
   int    c_val [1024];
   int    c_due [1024];
   int    c_wr = 0, c_rd = 0;
   int    cs [5][NT] = '{'{1, 0, 0, 0}, '{3, -5, 7, -2}, '{-128, -128, -128, -128},
                         '{127, -128, 0, 64}, '{-9, 4, -1, 11}};

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (q_rd != q_wr && q_due[q_rd & 1023] == cyc) begin
            checks++;
            if (!f_valid) begin
               errors++;
               $display("FAIL R3 out_valid=0 expected 1 at cycle %0d", cyc);
            end else if (int'(f_result) != q_val[q_rd & 1023]) begin
               errors++;
               $display("FAIL %s out_result=%0d expected %0d", cur_req, int'(f_result),
                        q_val[q_rd & 1023]);
            end
            q_rd++;
         end else if (f_valid) begin
            checks++; errors++;
            $display("FAIL R3 out_valid=1 expected 0 at cycle %0d", cyc);
         end
         if (c_rd != c_wr && c_due[c_rd & 1023] == cyc) begin
            checks++;
            if (!c_valid || int'(c_result) != c_val[c_rd & 1023]) begin
               errors++;
               $display("FAIL R8 valid=%0d result=%0d expected valid=1 result=%0d",
                        c_valid, int'(c_result), c_val[c_rd & 1023]);
            end
            c_rd++;
         end else if (c_valid) begin
            checks++; errors++;
            $display("FAIL R8 out_valid=1 expected 0 at cycle %0d", cyc);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0; in_valid = 1'b0; coef_we = 1'b0;
      q_rd = q_wr; c_rd = c_wr;
      for (int k = 0; k < NT; k++) begin hist[k] = 0; coef[k] = 0; end
      repeat (2) @(negedge clk);
      #1;
      checks++;
      if (f_valid !== 1'b0 || f_result !== '0 || c_valid !== 1'b0) begin
         errors++;
         $display("FAIL R6 reset valid=%0d result=%0d expected valid=0 result=0",
                  f_valid, int'(f_result));
      end
      rst_n = 1'b1;
   endtask

   task automatic load(input int idx, input int val);
      @(negedge clk); #1;
      in_valid = 1'b0;
      coef_we  = 1'b1;
      coef_idx = IW'(idx);
      coef_val = CW'(val);
      if (idx < NT) coef[idx] = val;
      @(negedge clk); #1;
      coef_we = 1'b0;
   endtask

   task automatic push(input int x);
      int e;
      @(negedge clk); #1;
      coef_we = 1'b0;
      in_valid = 1'b1;
      in_sample = DW'(x);
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      e = 0;
      for (int k = 0; k < NT; k++) e += coef[k] * hist[k];
      q_val[q_wr & 1023] = e; q_due[q_wr & 1023] = cyc + 3; q_wr++;
      c_val[c_wr & 1023] = x; c_due[c_wr & 1023] = cyc + 3; c_wr++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   initial begin
      do_reset();
      // R6: coefficients are zero after reset, so every output is zero
      cur_req = "R6";
      push(5); push(-7); push(-128);
      idle(6);

      for (int s = 0; s < 5; s++) begin
         case (s)
            0: cur_req = "R1";
            1: cur_req = "R2";
            2: cur_req = "R7";
            3: cur_req = "R5";
            default: cur_req = "R4";
         endcase
         do_reset();
         for (int k = 0; k < NT; k++) load(k, cs[s][k]);
         if (s == 3) for (int j = NT; j < 8; j++) load(j, 77 + j);
         for (int i = 0; i < 256; i++) begin
            push(((i * 37 + 11) & 255) - 128);
            if (s == 4 && (i % 3) == 1) idle(2);
         end
         // R7: repeated negative full scale drives the peak positive sum
         if (s == 2) for (int i = 0; i < NT; i++) push(-128);
         idle(6);
      end

      // R6: partial sums left by the last run must be gone after reset
      do_reset();
      cur_req = "R6";
      load(0, 1); load(1, 2); load(2, 3); load(3, 4);
      push(10); push(20); push(-30);
      idle(6);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule